// File: doc/BRIEF.md
# Transport Packet Output Formatter

This block sits at the tail of a receiver and hands decoded transport packets to an external byte port. Each incoming byte arrives with a valid strobe. A start marker identifies the sync byte of each packet, and an active-low uncorrectable-error indication is held for the whole packet. The formatter shows each byte either on all eight data pins at once or as a bit stream on a single pin. It produces a half-rate output clock whose rising edge falls in the middle of every output symbol. It also drives a data-valid pin whose active level can be chosen.

Mode bits come from a configuration word. The word is captured only when a packet's sync byte is accepted, so every packet leaves in one mode. When error marking is switched on (it also requires the derandomizer-enable bit), a packet flagged as uncorrectable has the top bit of its first data byte forced high. The sync byte is not a data byte, so the mark lands on the byte after it. The output clock can either run all the time or stay low during idle symbols. The source sets packet length through the start marker; a standard transport packet is 188 bytes.

Configuration word bits: 4 = valid polarity (1 means out_valid high marks data), 3 = clock free-running (1 means the clock runs during idle symbols), 2 = parallel (1) or serial (0), 1 = error marking enable, 0 = derandomizer enable.

Top module: `ts_out_fmt`

## Requirements
- R1: After reset the active mode is all ones, whatever cfg_mode holds: out_valid is low, out_data is 0 and out_clk keeps toggling while idle.
- R2: Every output symbol lasts two core cycles. out_clk is low in the first cycle and may be high only in the second, so out_clk is never high for two cycles in a row.
- R3: In serial mode (bit 2 = 0) a byte is sent MSB first over eight symbols on out_data[0].
- R4: In serial mode out_data[7] is 1 only on the first bit of each byte, and out_data[6:1] are 0 on every valid symbol.
- R5: When bits 1 and 0 are both 1 and in_err_n is 0, the first byte after the sync byte leaves with bit 7 set to 1.
- R6: Every other byte leaves unchanged. This covers the sync byte, bytes after the first data byte, packets with in_err_n = 1, and packets with bit 1 or bit 0 cleared.
- R7: out_valid equals bit 4 on valid symbols and equals its inverse on idle symbols.
- R8: With bit 3 = 0, out_clk stays low on idle symbols. With bit 3 = 1, out_clk pulses once per idle symbol.
- R9: cfg_mode is sampled only when a byte with in_start = 1 is accepted. Changing it in the middle of a packet has no effect until the next sync byte.
- R10: in_ready is never high two cycles running. Within a packet, a back-to-back stream is accepted every 2 cycles in parallel mode and every 16 cycles in serial mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_start | input | 1 | Input byte is a packet sync byte |
| in_data | input | W | Input byte |
| in_err_n | input | 1 | Low when the current packet is uncorrectable |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is high |
| cfg_mode | input | 5 | Mode word, captured on sync-byte acceptance |
| out_data | output | W | Parallel byte, or serial bit on [0] with byte start on [W-1] |
| out_valid | output | 1 | Data-valid strobe of programmable polarity |
| out_clk | output | 1 | Half-rate output clock, optionally gated when idle |

## Verification
The bench sweeps all 32 mode words against both error states and flips cfg_mode right after every sync byte. A design that sampled the word at any time other than sync acceptance would send part of a packet in the wrong shape or polarity. A design that placed the mark on the sync byte, on a later byte, or without both enable bits would miscompare on the first data byte, because the bench keeps bit 7 low there and on the byte after it. Idle gaps after each packet count clock pulses and check the idle valid level, which catches an inverted or ignored gating bit. The spacing between acceptances is measured to expose a serializer that drops or repeats bits.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;
  localparam int CFG_W = 5;

  typedef struct packed {
    logic vld_pol;   // bit 4
    logic clk_free;  // bit 3
    logic par;       // bit 2
    logic err_ins;   // bit 1
    logic derand;    // bit 0
  } mode_t;

  localparam mode_t MODE_RST = '{vld_pol: 1'b1, clk_free: 1'b1, par: 1'b1,
                                 err_ins: 1'b1, derand: 1'b1};
endpackage

// File: rtl/ts_cfg_hold.sv
module ts_cfg_hold
  import ts_out_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take_start,
  input  mode_t mode_in,
  output mode_t mode_act,
  output logic  sym_par,
  output logic  sym_pol
);
  // active mode is replaced only when a sync byte is accepted
  always_ff @(posedge clk) begin
    if (rst)             mode_act <= MODE_RST;
    else if (take_start) mode_act <= mode_in;
  end

  // the sync byte itself already uses the incoming word
  assign sym_par = take_start ? mode_in.par     : mode_act.par;
  assign sym_pol = take_start ? mode_in.vld_pol : mode_act.vld_pol;
endmodule

// File: rtl/ts_err_mark.sv
module ts_err_mark #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         start,
  input  logic         err_n,
  input  logic         ins_en,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] byte_o
);
  logic first_pend;
  logic hit;

  // set by the sync byte, cleared by whichever byte follows it
  always_ff @(posedge clk) begin
    if (rst)       first_pend <= 1'b0;
    else if (take) first_pend <= start;
  end

  assign hit    = take & ~start & first_pend & ins_en & ~err_n;
  assign byte_o = hit ? {1'b1, byte_i[W-2:0]} : byte_i;
endmodule

// File: rtl/ts_ser_drv.sv
module ts_ser_drv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] byte_i,
  input  logic         sym_par,
  input  logic         sym_pol,
  input  logic         act_pol,
  input  logic         act_free,
  output logic         ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  output logic         out_clk
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

  logic             phase;
  logic [CNT_W-1:0] bits_left;
  logic [W-1:0]     shreg;
  logic             sym_gate;

  assign ready = phase & (bits_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      bits_left <= '0;
      shreg     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_clk   <= 1'b0;
      sym_gate  <= 1'b0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        // second half of the symbol: rising edge if allowed
        out_clk <= sym_gate;
      end else begin
        // symbol boundary: load the next symbol
        out_clk <= 1'b0;
        if (bits_left != '0) begin
          out_data  <= {{(W-1){1'b0}}, shreg[W-1]};
          shreg     <= {shreg[W-2:0], 1'b0};
          bits_left <= bits_left - CNT_W'(1);
          out_valid <= act_pol;
          sym_gate  <= 1'b1;
        end else if (take) begin
          if (sym_par) begin
            out_data <= byte_i;
          end else begin
            out_data  <= {1'b1, {(W-2){1'b0}}, byte_i[W-1]};
            shreg     <= {byte_i[W-2:0], 1'b0};
            bits_left <= LAST_CNT;
          end
          out_valid <= sym_pol;
          sym_gate  <= 1'b1;
        end else begin
          out_data  <= '0;
          out_valid <= ~act_pol;
          sym_gate  <= act_free;
        end
      end
    end
  end
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
  import ts_out_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [W-1:0]     in_data,
  input  logic             in_err_n,
  output logic             in_ready,
  input  logic [CFG_W-1:0] cfg_mode,
  output logic [W-1:0]     out_data,
  output logic             out_valid,
  output logic             out_clk
);
  mode_t        mode_in;
  mode_t        mode_act;
  logic         sym_par;
  logic         sym_pol;
  logic         take;
  logic         take_start;
  logic         ins_en;
  logic [W-1:0] marked;

  assign mode_in    = mode_t'(cfg_mode);
  assign take       = in_valid & in_ready;
  assign take_start = take & in_start;
  assign ins_en     = mode_act.err_ins & mode_act.derand;

  ts_cfg_hold u_cfg (
    .clk        (clk),
    .rst        (rst),
    .take_start (take_start),
    .mode_in    (mode_in),
    .mode_act   (mode_act),
    .sym_par    (sym_par),
    .sym_pol    (sym_pol)
  );

  ts_err_mark #(.W(W)) u_mark (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .start  (in_start),
    .err_n  (in_err_n),
    .ins_en (ins_en),
    .byte_i (in_data),
    .byte_o (marked)
  );

  ts_ser_drv #(.W(W)) u_drv (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .byte_i    (marked),
    .sym_par   (sym_par),
    .sym_pol   (sym_pol),
    .act_pol   (mode_act.vld_pol),
    .act_free  (mode_act.clk_free),
    .ready     (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_clk   (out_clk)
  );
endmodule

// File: rtl/ts_out_chk.sv
module ts_out_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         out_clk,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         act_pol,
  input logic         act_free,
  input logic         act_par
);
  // R2
  clk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_clk |=> !out_clk);

  // R10
  ready_space_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_free && (out_valid != act_pol)) |-> !out_clk);

  // R4
  ser_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_par && (out_valid == act_pol)) |-> (out_data[W-2:1] == '0));
endmodule

bind ts_out_fmt ts_out_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_clk   (out_clk),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .act_pol   (mode_act.vld_pol),
  .act_free  (mode_act.clk_free),
  .act_par   (mode_act.par)
);

// File: tb/test_ts_out_fmt.sv
module test_ts_out_fmt;
  localparam int W  = 8;
  localparam int NB = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_start = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_err_n = 1'b1;
  logic         in_ready;
  logic [4:0]   cfg_mode = 5'h00;
  logic [W-1:0] out_data;
  logic         out_valid;
  logic         out_clk;

  ts_out_fmt #(.W(W)) i_ts_out_fmt (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_start (in_start),
    .in_data (in_data), .in_err_n (in_err_n), .in_ready (in_ready),
    .cfg_mode (cfg_mode), .out_data (out_data), .out_valid (out_valid),
    .out_clk (out_clk)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int cyc = 0;
  int last_acc = 0;

  logic [W-1:0] exp_data [0:8191];
  string        exp_tag  [0:8191];
  int wr = 0;
  int rd = 0;

  bit   mon_en = 1'b0;
  logic mon_pol = 1'b1;
  logic mon_free = 1'b1;
  logic prev_clk = 1'b0;
  int   idle_rises = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // output monitor: one symbol per rising edge of out_clk
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_clk && !prev_clk) begin
        if (out_valid == mon_pol) begin
          if (rd == wr) chk(1'b0, "R7 valid symbol with nothing pending", int'(out_data), 0);
          else begin
            chk(out_data == exp_data[rd], exp_tag[rd], int'(out_data), int'(exp_data[rd]));
            rd++;
          end
        end else begin
          idle_rises++;
        end
      end
      if (!mon_free && (out_valid != mon_pol) && out_clk)
        chk(1'b0, "R8 clock high on idle symbol", 1, 0);
      prev_clk = out_clk;
    end
  end

  task automatic send_byte(input logic [W-1:0] b, input bit st, input logic [4:0] m,
                           input logic [W-1:0] bx, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    in_start = st;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_start = 1'b0;
    // R10: acceptance spacing inside a packet
    if (!st) chk((cyc - last_acc) == (m[2] ? 2 : 2 * W), "R10 acceptance spacing",
                 cyc - last_acc, m[2] ? 2 : 2 * W);
    last_acc = cyc;
    if (st) begin
      mon_pol  = m[4];
      mon_free = m[3];
    end
    if (m[2]) begin
      exp_data[wr] = bx;
      exp_tag[wr]  = tag;
      wr++;
    end else begin
      for (int k = W - 1; k >= 0; k--) begin
        exp_data[wr] = {(k == W - 1) ? 1'b1 : 1'b0, {(W-2){1'b0}}, bx[k]};
        exp_tag[wr]  = tag;
        wr++;
      end
    end
  endtask

  task automatic send_packet(input logic [4:0] m, input logic errn, input int pk);
    logic [W-1:0] b;
    logic [W-1:0] bx;
    string tag;
    cfg_mode = m;
    in_err_n = errn;
    for (int i = 0; i < NB; i++) begin
      if (i == 0)      b = 8'h47;
      else if (i == 1) b = 8'((pk * 5 + 3) & 127);
      else if (i == 2) b = 8'h2A;
      else             b = 8'((pk * 29 + i * 71) | 128);
      bx  = b;
      tag = m[2] ? "R2/R9 parallel symbol" : "R3/R4/R9 serial symbol";
      if (i == 1) begin
        if (m[1] && m[0] && !errn) begin
          bx[W-1] = 1'b1;
          tag = {"R5 flagged first data byte, ", tag};
        end else begin
          tag = {"R6 unflagged first data byte, ", tag};
        end
      end else if (i == 0 || i == 2) begin
        tag = {"R6 byte left untouched, ", tag};
      end
      send_byte(b, i == 0, m, bx, tag);
      if (i == 0) cfg_mode = ~m;  // R9: mid-packet change must be ignored
    end
    for (int t = 0; t < 300 && rd != wr; t++) @(negedge clk);
    chk(rd == wr, "R7 all symbols seen at active valid level", rd, wr);
    @(negedge clk);
    #1;
    idle_rises = 0;
    repeat (12) @(negedge clk);
    #1;
    // R8: idle clock behaviour follows the packet's mode, not the flipped input
    chk(m[3] ? (idle_rises >= 4) : (idle_rises == 0), "R8 idle clock pulses",
        idle_rises, m[3] ? 6 : 0);
    chk(out_valid == ~m[4], "R7 idle valid level", int'(out_valid), int'(~m[4]));
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    mon_en = 1'b1;
    repeat (12) @(negedge clk);
    #1;
    // R1: defaults with cfg_mode held at zero
    chk(out_valid == 1'b0, "R1 reset valid level", int'(out_valid), 0);
    chk(out_data == '0, "R1 reset data", int'(out_data), 0);
    chk(idle_rises >= 4, "R1 clock runs after reset", idle_rises, 6);
    for (int c = 0; c < 32; c++) begin
      for (int e = 0; e < 2; e++) begin
        send_packet(c[4:0], e[0], c * 2 + e);
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", rd, wr);
      summary();
      $finish;
    end
  end
endmodule